// File: doc/BRIEF.md
# Multi-Mode Microcontroller I/O Port

This block is one configurable 8-bit port that sits between a microcontroller bus and a row of external pins. A mode register selects its role. In the default general-purpose role, an output register and a direction register drive the pins. In the address-capture role, the pins are inputs only, and their values are stored in a latch while the address-latch strobe is high, so the decoder has stable high-order address bits. In the data-port role, the general-purpose function is switched off and the pins carry a non-multiplexed data bus. In the peripheral role, the port is a bidirectional buffer for the data bus. This buffer only opens while one of two select lines from the address decoder is active.

A drive register can make each upper-nibble output open-drain. An open-drain pin only sinks current: it is driven when its value is 0 and released when its value is 1. Configuration is written through a small synchronous register port. Pin and bus direction are decided combinationally from the registered configuration and the live bus strobes.

Top module: `mcu_port_mux`

## Requirements
- R1: After reset, the mode, drive, output and direction registers are all 0. No pin is driven, the bus output enable is low and the address latch reads 0.
- R2: In general-purpose role, `pinOe` equals the direction register (1 = output) and the driven pins carry the output register. The register map on `cfgAddr` is: 0 = mode, 1 = drive, 2 = output, 3 = direction.
- R3: The address-capture role is selected by mode bit 1. In this role no pin is driven. `addrLatch` takes `pinIn` at each clock edge where `ale` is high and holds its value while `ale` is low. Outside this role, `ale` leaves the latch unchanged.
- R4: The data-port role is selected by mode bit 0 and ignores both select lines. When `wrN` alone is low, all pins are driven with `busIn`. When `rdN` alone is low, `busOe` is 1 and `busOut` equals `pinIn`. The output and direction registers have no effect in this role.
- R5: Peripheral buffering is enabled only by mode bit 7. Setting other mode bits (for example 0x40) leaves the port in general-purpose role.
- R6: With mode bit 7 set and either `selA` or `selB` high, the port buffers all 8 bits. A write strobe drives the pins from `busIn`, and a read strobe drives `busOut` from `pinIn`.
- R7: In peripheral role with both select lines low, no pin is driven and `busOe` is 0, whatever the strobes are.
- R8: If `rdN` and `wrN` are both low, or both high, neither the pins nor the bus are driven by the buffer roles.
- R9: For bit n in 7..4 with drive bit n set, a pin value of 0 is driven low (`pinOe`=1, `pinOut`=0) and a value of 1 releases the pin (`pinOe`=0). This applies in every role that drives pins.
- R10: Drive bits 3..0 have no effect: the lower nibble is always push-pull.
- R11: When mode bits 0 and 7 are both set, the data-port role wins and the select lines are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | 8 | Configuration write data |
| ale | input | 1 | Address-latch strobe, active high |
| selA | input | 1 | Peripheral select line A |
| selB | input | 1 | Peripheral select line B |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 8 | Microcontroller data bus toward pins |
| pinIn | input | 8 | Sampled pin levels |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output value |
| busOut | output | 8 | Data returned to the bus (0 when idle) |
| busOe | output | 1 | Bus output enable |
| addrLatch | output | 8 | Captured address bits |

## Verification
Two functions can meet in one cycle. The first is the strobe-driven direction choice of the buffer roles. The second is the open-drain override: a bus write into the pins can present 1s on open-drain bits, so both act on the same pins at once. The vectors provoke this with a peripheral write of 0xF0 while the upper drive bits are set, and the bench expects the upper pins to be released and the lower pins to be driven low. A second collision is both strobes low in one cycle. It is provoked in the peripheral and data-port roles, and the bench expects no drive in either direction.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int PORT_W   = 8;
  localparam int OD_LOW   = 4;
  localparam int MODE_DP  = 0;
  localparam int MODE_ADR = 1;
  localparam int MODE_PER = 7;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_DRIVE = 2'd1;
  localparam logic [1:0] REG_OUT   = 2'd2;
  localparam logic [1:0] REG_DIR   = 2'd3;

  typedef enum logic [1:0] {
    ROLE_GPIO = 2'd0,
    ROLE_ADDR = 2'd1,
    ROLE_DATA = 2'd2,
    ROLE_PERI = 2'd3
  } portRole_t;

  typedef struct packed {
    logic pinFromBus;
    logic busFromPin;
    logic pinsFromGpio;
    logic captureAddr;
  } portStrobes_t;
endpackage

// File: rtl/mcu_port_ctrl.sv
module mcu_port_ctrl
  import mcu_port_pkg::*;
#(
  parameter int WIDTH = PORT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   modeReg,
  input  logic               ale,
  input  logic               selA,
  input  logic               selB,
  input  logic               rdN,
  input  logic               wrN,
  output portStrobes_t       strobes
);
  portRole_t role;
  logic      selAny;
  logic      rdOnly;
  logic      wrOnly;

  assign selAny = selA | selB;
  assign rdOnly = !rdN && wrN;
  assign wrOnly = !wrN && rdN;

  // Role priority: data port, then peripheral, then address capture.
  always_comb begin
    if (modeReg[MODE_DP])       role = ROLE_DATA;
    else if (modeReg[MODE_PER]) role = ROLE_PERI;
    else if (modeReg[MODE_ADR]) role = ROLE_ADDR;
    else                        role = ROLE_GPIO;
  end

  always_comb begin
    strobes = '0;
    unique case (role)
      ROLE_DATA: begin
        strobes.pinFromBus = wrOnly;
        strobes.busFromPin = rdOnly;
      end
      ROLE_PERI: begin
        strobes.pinFromBus = wrOnly && selAny;
        strobes.busFromPin = rdOnly && selAny;
      end
      ROLE_ADDR: strobes.captureAddr  = ale;
      default:   strobes.pinsFromGpio = 1'b1;
    endcase
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.pinFromBus, strobes.busFromPin, strobes.pinsFromGpio})); // R8
  AST_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |-> (!strobes.pinFromBus && !strobes.busFromPin)); // R8
  AST_NO_SELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MODE_PER] && !modeReg[MODE_DP] && !selA && !selB)
      |-> (!strobes.pinFromBus && !strobes.busFromPin)); // R7
  AST_DATA_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MODE_DP] && !wrN && rdN) |-> strobes.pinFromBus); // R11
  AST_GPIO_OFF_IN_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[MODE_DP] || modeReg[MODE_PER]) |-> !strobes.pinsFromGpio); // R4
endmodule

// File: rtl/mcu_port_dp.sv
module mcu_port_dp
  import mcu_port_pkg::*;
#(
  parameter int WIDTH = PORT_W,
  parameter int ODLO  = OD_LOW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgAddr,
  input  logic [WIDTH-1:0]   cfgData,
  input  portStrobes_t       strobes,
  input  logic [WIDTH-1:0]   busIn,
  input  logic [WIDTH-1:0]   pinIn,
  output logic [WIDTH-1:0]   modeReg,
  output logic [WIDTH-1:0]   pinOe,
  output logic [WIDTH-1:0]   pinOut,
  output logic [WIDTH-1:0]   busOut,
  output logic               busOe,
  output logic [WIDTH-1:0]   addrLatch
);
  logic [WIDTH-1:0] driveReg;
  logic [WIDTH-1:0] outReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] rawOe;
  logic [WIDTH-1:0] rawVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      driveReg <= '0;
      outReg   <= '0;
      dirReg   <= '0;
    end else if (cfgWrEn) begin
      unique case (cfgAddr)
        REG_MODE:  modeReg  <= cfgData;
        REG_DRIVE: driveReg <= cfgData;
        REG_OUT:   outReg   <= cfgData;
        default:   dirReg   <= cfgData;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    addrLatch <= '0;
    else if (strobes.captureAddr) addrLatch <= pinIn;
  end

  always_comb begin
    if (strobes.pinFromBus) begin
      rawOe  = '1;
      rawVal = busIn;
    end else if (strobes.pinsFromGpio) begin
      rawOe  = dirReg;
      rawVal = outReg;
    end else begin
      rawOe  = '0;
      rawVal = outReg;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= ODLO) begin : g_od
      logic odOn;
      assign odOn     = driveReg[i];
      assign pinOe[i] = rawOe[i] && !(odOn && rawVal[i]);
      assign pinOut[i] = rawVal[i] && !odOn;

      AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
        driveReg[i] |-> !(pinOe[i] && pinOut[i])); // R9
    end else begin : g_cmos
      assign pinOe[i]  = rawOe[i];
      assign pinOut[i] = rawVal[i];

      AST_LOW_PUSH_PULL: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.pinFromBus) |-> (pinOe[i] && pinOut[i] == busIn[i])); // R10
    end
  end

  assign busOe  = strobes.busFromPin;
  assign busOut = strobes.busFromPin ? pinIn : '0;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureAddr |=> $stable(addrLatch)); // R3
  AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureAddr |=> addrLatch == $past(pinIn)); // R3
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busOut == '0); // R8
endmodule

// File: rtl/mcu_port_mux.sv
module mcu_port_mux
  import mcu_port_pkg::*;
#(
  parameter int WIDTH = PORT_W,
  parameter int ODLO  = OD_LOW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [WIDTH-1:0] cfgData,
  input  logic             ale,
  input  logic             selA,
  input  logic             selB,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [WIDTH-1:0] busIn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] busOut,
  output logic             busOe,
  output logic [WIDTH-1:0] addrLatch
);
  portStrobes_t     strobes;
  logic [WIDTH-1:0] modeReg;

  mcu_port_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeReg(modeReg), .ale(ale),
    .selA(selA), .selB(selB), .rdN(rdN), .wrN(wrN), .strobes(strobes)
  );

  mcu_port_dp #(.WIDTH(WIDTH), .ODLO(ODLO)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .strobes(strobes), .busIn(busIn), .pinIn(pinIn),
    .modeReg(modeReg), .pinOe(pinOe), .pinOut(pinOut), .busOut(busOut),
    .busOe(busOe), .addrLatch(addrLatch)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && !busOe)); // R1
endmodule

// File: tb/sim_mcu_port_mux.sv
`timescale 1ns/1ps
module sim_mcu_port_mux;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       ale = 1'b0, selA = 1'b0, selB = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] busIn = '0, pinIn = '0;
  logic [7:0] pinOe, pinOut, busOut, addrLatch;
  logic       busOe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mcu_port_mux u0 (.*);

  typedef struct packed {
    logic [7:0] mode, drive, outv, dir;
    logic [1:0] sel;
    logic       rdN, wrN;
    logic [7:0] bus, pin, eOe, eOut;
    logic       eBusOe;
    logic [7:0] eBus;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h00,8'h00,8'hA5,8'hF0,2'b00,1'b1,1'b1,8'h00,8'h00,8'hF0,8'hA0,1'b0,8'h00,8'd2},  // R2
    '{8'h00,8'h00,8'h3C,8'hFF,2'b00,1'b1,1'b1,8'h00,8'h00,8'hFF,8'h3C,1'b0,8'h00,8'd2},  // R2
    '{8'h00,8'hF0,8'h5A,8'hFF,2'b00,1'b1,1'b1,8'h00,8'h00,8'hAF,8'h0A,1'b0,8'h00,8'd9},  // R9
    '{8'h00,8'h0F,8'h5A,8'hFF,2'b00,1'b1,1'b1,8'h00,8'h00,8'hFF,8'h5A,1'b0,8'h00,8'd10}, // R10
    '{8'h01,8'h00,8'h00,8'h00,2'b00,1'b1,1'b0,8'hC3,8'h00,8'hFF,8'hC3,1'b0,8'h00,8'd4},  // R4
    '{8'h01,8'h00,8'hFF,8'hFF,2'b00,1'b0,1'b1,8'h00,8'h96,8'h00,8'h00,1'b1,8'h96,8'd4},  // R4
    '{8'h80,8'h00,8'h00,8'h00,2'b01,1'b1,1'b0,8'h7E,8'h00,8'hFF,8'h7E,1'b0,8'h00,8'd6},  // R6
    '{8'h80,8'h00,8'h00,8'h00,2'b10,1'b0,1'b1,8'h00,8'h81,8'h00,8'h00,1'b1,8'h81,8'd6},  // R6
    '{8'h80,8'h00,8'hFF,8'hFF,2'b00,1'b1,1'b0,8'h55,8'h00,8'h00,8'h00,1'b0,8'h00,8'd7},  // R7
    '{8'h80,8'h00,8'h00,8'h00,2'b11,1'b0,1'b0,8'h55,8'h66,8'h00,8'h00,1'b0,8'h00,8'd8},  // R8
    '{8'h01,8'h00,8'h00,8'h00,2'b00,1'b0,1'b0,8'h55,8'h66,8'h00,8'h00,1'b0,8'h00,8'd8},  // R8
    '{8'h81,8'h00,8'h00,8'h00,2'b00,1'b1,1'b0,8'h11,8'h00,8'hFF,8'h11,1'b0,8'h00,8'd11}, // R11
    '{8'h80,8'hF0,8'h00,8'h00,2'b01,1'b1,1'b0,8'hF0,8'h00,8'h0F,8'h00,1'b0,8'h00,8'd9},  // R9
    '{8'h40,8'h00,8'h05,8'h0F,2'b01,1'b1,1'b0,8'hFF,8'h00,8'h0F,8'h05,1'b0,8'h00,8'd5},  // R5
    '{8'h02,8'h00,8'hFF,8'hFF,2'b00,1'b1,1'b1,8'h00,8'h00,8'h00,8'h00,1'b0,8'h00,8'd3}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    check("R1 reset pinOe", pinOe, 8'h00);
    check("R1 reset busOe", busOe, 1'b0);
    check("R1 reset latch", addrLatch, 8'h00);

    for (int v = 0; v < NV; v++) begin
      writeCfg(REG_IDX_MODE, VECS[v].mode);
      writeCfg(2'd1, VECS[v].drive);
      writeCfg(2'd2, VECS[v].outv);
      writeCfg(2'd3, VECS[v].dir);
      @(negedge clk);
      {selB, selA} = VECS[v].sel;
      rdN = VECS[v].rdN; wrN = VECS[v].wrN;
      busIn = VECS[v].bus; pinIn = VECS[v].pin;
      settle();
      check($sformatf("R%0d vec%0d pinOe", VECS[v].req, v), pinOe, VECS[v].eOe);
      check($sformatf("R%0d vec%0d pinOut", VECS[v].req, v), pinOut & pinOe, VECS[v].eOut);
      check($sformatf("R%0d vec%0d busOe", VECS[v].req, v), busOe, VECS[v].eBusOe);
      check($sformatf("R%0d vec%0d busOut", VECS[v].req, v), busOut, VECS[v].eBus);
      @(negedge clk);
      rdN = 1'b1; wrN = 1'b1; selA = 1'b0; selB = 1'b0;
    end

    // R3: capture in address role, hold when strobe low
    writeCfg(2'd0, 8'h02);
    @(negedge clk); pinIn = 8'h5C; ale = 1'b1;
    @(negedge clk); ale = 1'b0; pinIn = 8'h33;
    settle();
    check("R3 captured", addrLatch, 8'h5C);
    repeat (2) @(negedge clk);
    check("R3 held", addrLatch, 8'h5C);
    // R3: strobe ignored in general-purpose role
    writeCfg(2'd0, 8'h00);
    @(negedge clk); ale = 1'b1; pinIn = 8'hE1;
    @(negedge clk); ale = 1'b0;
    settle();
    check("R3 no capture outside role", addrLatch, 8'h5C);

    // R1: reset in mid-run clears configuration
    writeCfg(2'd3, 8'hFF);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    settle();
    check("R1 mid-run reset pinOe", pinOe, 8'h00);
    check("R1 mid-run reset latch", addrLatch, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [1:0] REG_IDX_MODE = 2'd0;
endmodule